// File: doc/BRIEF.md
# Associative Page Address Translator

This block holds one page register per physical page of a paged main store. Each register records which logical block currently occupies its page, whether the entry is valid, and whether the page is locked while a transfer to or from backing store is under way. Each store request carries a logical word address. The block number part of that address is compared with every register at once. A single usable match yields a physical address built from the page index and the word offset. When nothing matches, the block raises a page fault so that software can fetch the block.

Two request ports are translated in the same cycle: one for instruction fetches and one for operand accesses. A command port lets software manage the table. It can load a page register, rename a block in place, lock or unlock a page, and drop a page. Commands take effect at the clock edge that samples them. Translation results are registered and appear one cycle after the request.

Top module: `pat_xlate`

## Requirements
- R1: After reset every register is invalid and unlocked, so any request is answered with a fault.
- R2: The request address is 20 bits. Bits 8:0 are the word offset and bits 19:9 are the block number. When exactly one valid, unlocked register holds that block number, the port reports hit one cycle after the request. The physical address it returns is {page index (5 bits), offset (9 bits)}.
- R3: When no valid register holds the block number, the port reports fault one cycle after the request, with a physical address of zero.
- R4: When one or more valid registers match but every one of them is locked, the port reports busy. It reports neither hit nor fault.
- R5: When two or more valid, unlocked registers match, the port reports the error flag and does not report a hit. A locked duplicate does not count toward this condition.
- R6: Command LOAD (op code 0) makes register cmd_page valid and holding cmd_blk_a. Every command is seen by lookups from the following cycle onward. A lookup issued in the same cycle as a command sees the old table.
- R7: Command RENAME (op code 1) is given a source block in cmd_blk_a and a destination block in cmd_blk_b. Every valid register that holds the destination is invalidated, and every valid register that holds the source is changed to hold the destination.
- R8: If no register holds the source, RENAME only invalidates the destination. A RENAME whose source and destination are equal changes nothing.
- R9: Command LOCK (op code 2) sets the lock bit of page cmd_page, and UNLOCK (op code 3) clears it. The block number and the valid bit are unchanged.
- R10: Command DROP (op code 4) invalidates page cmd_page. Op codes 5 to 7 change nothing.
- R11: The instruction port and the operand port translate independently in the same cycle, each with its own outcome.
- R12: A port with no request shows all of its outcome flags and its physical address at zero in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Table command strobe |
| cmd_op | input | 3 | Command code: 0 load, 1 rename, 2 lock, 3 unlock, 4 drop |
| cmd_page | input | 5 | Page index for load, lock, unlock and drop |
| cmd_blk_a | input | 11 | Block to load, or rename source |
| cmd_blk_b | input | 11 | Rename destination |
| ins_req | input | 1 | Instruction fetch translation request |
| ins_addr | input | 20 | Instruction logical address |
| ins_hit | output | 1 | Instruction translation succeeded |
| ins_fault | output | 1 | Instruction block not present |
| ins_busy | output | 1 | Instruction block present only in locked pages |
| ins_err | output | 1 | Instruction block matched several usable pages |
| ins_paddr | output | 14 | Instruction physical address |
| opd_req | input | 1 | Operand translation request |
| opd_addr | input | 20 | Operand logical address |
| opd_hit | output | 1 | Operand translation succeeded |
| opd_fault | output | 1 | Operand block not present |
| opd_busy | output | 1 | Operand block present only in locked pages |
| opd_err | output | 1 | Operand block matched several usable pages |
| opd_paddr | output | 14 | Operand physical address |

## Verification
Two functions can fall in the same cycle: a table command and a lookup on either port. The bench provokes this by issuing LOAD and RENAME on the same clock edge as an instruction lookup of the affected block. It then expects the outcome that the table held before the command, for example a fault for a block that is being loaded. A lookup in the next cycle must show the updated table. Both ports are also driven together across all 32 pages, with crossed page choices and mirrored offsets, to show that neither port disturbs the other.

// File: rtl/pat_pkg.sv
package pat_pkg;

    localparam int unsigned PAT_NPAGE_DEF = 32;
    localparam int unsigned PAT_BLK_W_DEF = 11;
    localparam int unsigned PAT_OFF_W_DEF = 9;

    typedef enum logic [2:0] {
        OP_LOAD   = 3'd0,
        OP_RENAME = 3'd1,
        OP_LOCK   = 3'd2,
        OP_UNLOCK = 3'd3,
        OP_DROP   = 3'd4
    } pat_op_e;

endpackage

// File: rtl/pat_table.sv
module pat_table
    import pat_pkg::*;
#(
    parameter int unsigned NPAGE  = PAT_NPAGE_DEF,
    parameter int unsigned BLK_W  = PAT_BLK_W_DEF,
    parameter int unsigned PIDX_W = $clog2(NPAGE)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cmd_valid,
    input  logic [2:0]                   cmd_op,
    input  logic [PIDX_W-1:0]            cmd_page,
    input  logic [BLK_W-1:0]             cmd_blk_a,
    input  logic [BLK_W-1:0]             cmd_blk_b,
    output logic [NPAGE-1:0]             valid_o,
    output logic [NPAGE-1:0]             lock_o,
    output logic [NPAGE-1:0][BLK_W-1:0]  blk_o
);

    typedef struct packed {
        logic [NPAGE-1:0]            valid;
        logic [NPAGE-1:0]            lock;
        logic [NPAGE-1:0][BLK_W-1:0] blk;
    } tbl_t;

    tbl_t    st_d, st_q;
    pat_op_e op;

    assign op = pat_op_e'(cmd_op);

    always_comb begin
        st_d = st_q;
        if (cmd_valid) begin
            case (op)
                OP_LOAD: begin
                    st_d.valid[cmd_page] = 1'b1;
                    st_d.blk[cmd_page]   = cmd_blk_a;
                end
                OP_RENAME: begin
                    if (cmd_blk_a != cmd_blk_b) begin
                        for (int i = 0; i < NPAGE; i++) begin
                            if (st_q.valid[i] && st_q.blk[i] == cmd_blk_b) begin
                                st_d.valid[i] = 1'b0;
                            end else if (st_q.valid[i] && st_q.blk[i] == cmd_blk_a) begin
                                st_d.blk[i] = cmd_blk_b;
                            end
                        end
                    end
                end
                OP_LOCK:   st_d.lock[cmd_page]  = 1'b1;
                OP_UNLOCK: st_d.lock[cmd_page]  = 1'b0;
                OP_DROP:   st_d.valid[cmd_page] = 1'b0;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.valid;
    assign lock_o  = st_q.lock;
    assign blk_o   = st_q.blk;

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && op == OP_LOAD |=>
            valid_o[$past(cmd_page)] && blk_o[$past(cmd_page)] == $past(cmd_blk_a)); // R6

    AST_LOCK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && op == OP_LOCK |=> lock_o[$past(cmd_page)]); // R9

    AST_UNLOCK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && op == OP_UNLOCK |=> !lock_o[$past(cmd_page)]); // R9

    AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && op == OP_DROP |=> !valid_o[$past(cmd_page)]); // R10

    for (genvar g = 0; g < NPAGE; g++) begin : g_chk
        AST_RENAME_SRC_GONE: assert property (@(posedge clk) disable iff (!rst_n)
            cmd_valid && op == OP_RENAME && cmd_blk_a != cmd_blk_b |=>
                !(valid_o[g] && blk_o[g] == $past(cmd_blk_a))); // R7
    end

endmodule

// File: rtl/pat_lookup.sv
module pat_lookup
    import pat_pkg::*;
#(
    parameter int unsigned NPAGE  = PAT_NPAGE_DEF,
    parameter int unsigned BLK_W  = PAT_BLK_W_DEF,
    parameter int unsigned OFF_W  = PAT_OFF_W_DEF,
    parameter int unsigned PIDX_W = $clog2(NPAGE),
    parameter int unsigned ADDR_W = BLK_W + OFF_W,
    parameter int unsigned PA_W   = PIDX_W + OFF_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [NPAGE-1:0]             valid_i,
    input  logic [NPAGE-1:0]             lock_i,
    input  logic [NPAGE-1:0][BLK_W-1:0]  blk_i,
    output logic                         hit,
    output logic                         fault,
    output logic                         busy,
    output logic                         err,
    output logic [PA_W-1:0]              paddr
);

    typedef struct packed {
        logic            hit;
        logic            fault;
        logic            busy;
        logic            err;
        logic [PA_W-1:0] paddr;
    } res_t;

    res_t               res_d, res_q;
    logic [BLK_W-1:0]   key;
    logic [OFF_W-1:0]   off;
    logic [NPAGE-1:0]   match;
    logic [NPAGE-1:0]   usable;
    logic [PIDX_W:0]    n_usable;
    logic [PIDX_W-1:0]  idx;

    assign key = addr[OFF_W +: BLK_W];
    assign off = addr[OFF_W-1:0];

    for (genvar g = 0; g < NPAGE; g++) begin : g_cmp
        assign match[g]  = valid_i[g] && (blk_i[g] == key);
        assign usable[g] = match[g] && !lock_i[g];
    end

    always_comb begin
        n_usable = '0;
        idx      = '0;
        for (int i = 0; i < NPAGE; i++) begin
            n_usable = n_usable + (PIDX_W+1)'(usable[i]);
            if (usable[i]) begin
                idx = PIDX_W'(i);
            end
        end
    end

    always_comb begin
        res_d = '0;
        if (req) begin
            if (n_usable == (PIDX_W+1)'(1)) begin
                res_d.hit   = 1'b1;
                res_d.paddr = {idx, off};
            end else if (n_usable > (PIDX_W+1)'(1)) begin
                res_d.err = 1'b1;
            end else if (|match) begin
                res_d.busy = 1'b1;
            end else begin
                res_d.fault = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign hit   = res_q.hit;
    assign fault = res_q.fault;
    assign busy  = res_q.busy;
    assign err   = res_q.err;
    assign paddr = res_q.paddr;

    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> $countones({hit, fault, busy, err}) == 1); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !hit && !fault && !busy && !err && paddr == '0); // R12

    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !hit || paddr[OFF_W-1:0] == $past(addr[OFF_W-1:0])); // R2

    AST_MISS_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        fault || busy || err |-> paddr == '0); // R3

endmodule

// File: rtl/pat_xlate.sv
module pat_xlate
    import pat_pkg::*;
#(
    parameter int unsigned NPAGE  = PAT_NPAGE_DEF,
    parameter int unsigned BLK_W  = PAT_BLK_W_DEF,
    parameter int unsigned OFF_W  = PAT_OFF_W_DEF,
    parameter int unsigned PIDX_W = $clog2(NPAGE),
    parameter int unsigned ADDR_W = BLK_W + OFF_W,
    parameter int unsigned PA_W   = PIDX_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [PIDX_W-1:0] cmd_page,
    input  logic [BLK_W-1:0]  cmd_blk_a,
    input  logic [BLK_W-1:0]  cmd_blk_b,
    input  logic              ins_req,
    input  logic [ADDR_W-1:0] ins_addr,
    output logic              ins_hit,
    output logic              ins_fault,
    output logic              ins_busy,
    output logic              ins_err,
    output logic [PA_W-1:0]   ins_paddr,
    input  logic              opd_req,
    input  logic [ADDR_W-1:0] opd_addr,
    output logic              opd_hit,
    output logic              opd_fault,
    output logic              opd_busy,
    output logic              opd_err,
    output logic [PA_W-1:0]   opd_paddr
);

    localparam int unsigned NPORT = 2;

    logic [NPAGE-1:0]            tbl_valid;
    logic [NPAGE-1:0]            tbl_lock;
    logic [NPAGE-1:0][BLK_W-1:0] tbl_blk;

    logic [NPORT-1:0]            p_req;
    logic [ADDR_W-1:0]           p_addr  [NPORT];
    logic [NPORT-1:0]            p_hit, p_fault, p_busy, p_err;
    logic [PA_W-1:0]             p_paddr [NPORT];

    pat_table #(
        .NPAGE (NPAGE),
        .BLK_W (BLK_W),
        .PIDX_W(PIDX_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_valid(cmd_valid),
        .cmd_op   (cmd_op),
        .cmd_page (cmd_page),
        .cmd_blk_a(cmd_blk_a),
        .cmd_blk_b(cmd_blk_b),
        .valid_o  (tbl_valid),
        .lock_o   (tbl_lock),
        .blk_o    (tbl_blk)
    );

    assign p_req[0]  = ins_req;
    assign p_addr[0] = ins_addr;
    assign p_req[1]  = opd_req;
    assign p_addr[1] = opd_addr;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        pat_lookup #(
            .NPAGE (NPAGE),
            .BLK_W (BLK_W),
            .OFF_W (OFF_W),
            .PIDX_W(PIDX_W),
            .ADDR_W(ADDR_W),
            .PA_W  (PA_W)
        ) u_lookup (
            .clk    (clk),
            .rst_n  (rst_n),
            .req    (p_req[p]),
            .addr   (p_addr[p]),
            .valid_i(tbl_valid),
            .lock_i (tbl_lock),
            .blk_i  (tbl_blk),
            .hit    (p_hit[p]),
            .fault  (p_fault[p]),
            .busy   (p_busy[p]),
            .err    (p_err[p]),
            .paddr  (p_paddr[p])
        );
    end

    assign ins_hit   = p_hit[0];
    assign ins_fault = p_fault[0];
    assign ins_busy  = p_busy[0];
    assign ins_err   = p_err[0];
    assign ins_paddr = p_paddr[0];
    assign opd_hit   = p_hit[1];
    assign opd_fault = p_fault[1];
    assign opd_busy  = p_busy[1];
    assign opd_err   = p_err[1];
    assign opd_paddr = p_paddr[1];

endmodule

// File: tb/pat_xlate_test.sv
`timescale 1ns/1ps
module pat_xlate_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [4:0]  cmd_page = '0;
    logic [10:0] cmd_blk_a = '0, cmd_blk_b = '0;
    logic        ins_req = 1'b0, opd_req = 1'b0;
    logic [19:0] ins_addr = '0, opd_addr = '0;
    logic        ins_hit, ins_fault, ins_busy, ins_err;
    logic        opd_hit, opd_fault, opd_busy, opd_err;
    logic [13:0] ins_paddr, opd_paddr;

    int n_cmp = 0;
    int n_bad = 0;

    logic        mv [32];
    logic        ml [32];
    logic [10:0] mb [32];

    always #4 clk = ~clk;

    pat_xlate uut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_page(cmd_page),
        .cmd_blk_a(cmd_blk_a), .cmd_blk_b(cmd_blk_b),
        .ins_req(ins_req), .ins_addr(ins_addr),
        .ins_hit(ins_hit), .ins_fault(ins_fault), .ins_busy(ins_busy),
        .ins_err(ins_err), .ins_paddr(ins_paddr),
        .opd_req(opd_req), .opd_addr(opd_addr),
        .opd_hit(opd_hit), .opd_fault(opd_fault), .opd_busy(opd_busy),
        .opd_err(opd_err), .opd_paddr(opd_paddr)
    );

    function automatic logic [10:0] blk_of(input int i);
        return 11'((i * 67 + 3) % 2048);
    endfunction

    // expected {hit, fault, busy, err, paddr} from the requirement rules
    function automatic logic [17:0] expect_of(input logic [19:0] a);
        int nu = 0;
        int nl = 0;
        int pg = 0;
        for (int i = 0; i < 32; i++) begin
            if (mv[i] && mb[i] == a[19:9]) begin
                if (ml[i]) nl++;
                else begin nu++; pg = i; end
            end
        end
        if (nu == 1) return {4'b1000, 14'(pg * 512 + int'(a[8:0]))};
        if (nu > 1)  return {4'b0001, 14'd0};
        if (nl > 0)  return {4'b0010, 14'd0};
        return {4'b0100, 14'd0};
    endfunction

    function automatic void model_apply(input logic [2:0] op, input logic [4:0] pg,
                                        input logic [10:0] a, input logic [10:0] b);
        case (op)
            3'd0: begin mv[pg] = 1'b1; mb[pg] = a; end
            3'd1: if (a != b) begin
                for (int i = 0; i < 32; i++) begin
                    if (mv[i] && mb[i] == b) mv[i] = 1'b0;
                    else if (mv[i] && mb[i] == a) mb[i] = b;
                end
            end
            3'd2: ml[pg] = 1'b1;
            3'd3: ml[pg] = 1'b0;
            3'd4: mv[pg] = 1'b0;
            default: ;
        endcase
    endfunction

    task automatic compare(input logic [17:0] got, input logic [17:0] exp, input string tag);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic do_cmd(input logic [2:0] op, input logic [4:0] pg,
                          input logic [10:0] a, input logic [10:0] b);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_page = pg; cmd_blk_a = a; cmd_blk_b = b;
        @(negedge clk);
        cmd_valid = 1'b0;
        model_apply(op, pg, a, b);
    endtask

    task automatic look2(input logic [19:0] ia, input logic [19:0] oa, input string tag);
        logic [17:0] ei, eo;
        ei = expect_of(ia);
        eo = expect_of(oa);
        @(negedge clk);
        ins_req = 1'b1; ins_addr = ia; opd_req = 1'b1; opd_addr = oa;
        @(negedge clk);
        ins_req = 1'b0; opd_req = 1'b0;
        compare({ins_hit, ins_fault, ins_busy, ins_err, ins_paddr}, ei, {tag, " ins"});
        compare({opd_hit, opd_fault, opd_busy, opd_err, opd_paddr}, eo, {tag, " opd"});
    endtask

    // command and instruction lookup on the same edge: lookup sees the old table
    task automatic cmd_with_look(input logic [2:0] op, input logic [4:0] pg,
                                 input logic [10:0] a, input logic [10:0] b,
                                 input logic [19:0] ia, input string tag);
        logic [17:0] ei;
        ei = expect_of(ia);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_page = pg; cmd_blk_a = a; cmd_blk_b = b;
        ins_req = 1'b1; ins_addr = ia;
        @(negedge clk);
        cmd_valid = 1'b0; ins_req = 1'b0;
        model_apply(op, pg, a, b);
        compare({ins_hit, ins_fault, ins_busy, ins_err, ins_paddr}, ei, tag);
    endtask

    task automatic idle_check(input string tag);
        @(negedge clk);
        compare({ins_hit, ins_fault, ins_busy, ins_err, ins_paddr}, 18'd0, {tag, " ins"});
        compare({opd_hit, opd_fault, opd_busy, opd_err, opd_paddr}, 18'd0, {tag, " opd"});
    endtask

    function automatic logic [19:0] mk(input logic [10:0] b, input int off);
        return {b, 9'(off)};
    endfunction

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 32; i++) begin mv[i] = 1'b0; ml[i] = 1'b0; mb[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R12: reset state quiet, then everything faults
        idle_check("R12 reset idle");
        look2(mk(11'd0, 0), mk(11'd2047, 511), "R1 empty table");

        // R6: load concurrent with lookup sees old contents, then new
        cmd_with_look(3'd0, 5'd0, blk_of(0), 11'd0, mk(blk_of(0), 7), "R6 same-cycle load");
        look2(mk(blk_of(0), 7), mk(blk_of(0), 8), "R6 load visible");

        for (int i = 1; i < 32; i++) do_cmd(3'd0, 5'(i), blk_of(i), 11'd0);

        // R2 / R11: sweep all pages on both ports with crossed pages and offsets
        for (int i = 0; i < 32; i++) begin
            for (int k = 0; k < 4; k++) begin
                int off;
                off = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 255 : 511;
                look2(mk(blk_of(i), off), mk(blk_of(31 - i), 511 - off), "R2 R11 sweep");
            end
        end

        // R3: misses
        for (int b = 1000; b < 1008; b++) look2(mk(11'(b), b), mk(11'(b + 500), 3), "R3 miss");
        idle_check("R12 idle after sweep");

        // R4 / R9: lock then unlock
        do_cmd(3'd2, 5'd5, 11'd0, 11'd0);
        look2(mk(blk_of(5), 17), mk(blk_of(6), 17), "R4 R9 locked busy");
        do_cmd(3'd3, 5'd5, 11'd0, 11'd0);
        look2(mk(blk_of(5), 18), mk(blk_of(5), 19), "R9 unlocked hit");

        // R5: duplicate usable entries give the error flag
        do_cmd(3'd0, 5'd7, blk_of(6), 11'd0);
        look2(mk(blk_of(6), 4), mk(blk_of(7), 4), "R5 duplicate error");
        do_cmd(3'd2, 5'd7, 11'd0, 11'd0);
        look2(mk(blk_of(6), 5), mk(blk_of(6), 6), "R5 R4 locked duplicate ignored");
        do_cmd(3'd2, 5'd6, 11'd0, 11'd0);
        look2(mk(blk_of(6), 5), mk(blk_of(8), 6), "R4 all copies locked");
        do_cmd(3'd3, 5'd6, 11'd0, 11'd0);
        do_cmd(3'd3, 5'd7, 11'd0, 11'd0);

        // R10: drop
        do_cmd(3'd4, 5'd7, 11'd0, 11'd0);
        look2(mk(blk_of(6), 9), mk(blk_of(7), 9), "R10 drop");

        // R7: rename with same-cycle lookup, then new view
        cmd_with_look(3'd1, 5'd0, blk_of(10), blk_of(11), mk(blk_of(10), 33), "R7 R6 same-cycle rename");
        look2(mk(blk_of(11), 34), mk(blk_of(10), 34), "R7 rename result");

        // R8: absent source still removes destination; equal pair does nothing
        do_cmd(3'd1, 5'd0, 11'd1500, blk_of(12));
        look2(mk(blk_of(12), 1), mk(11'd1500, 1), "R8 absent source");
        do_cmd(3'd1, 5'd0, blk_of(13), blk_of(13));
        look2(mk(blk_of(13), 2), mk(blk_of(14), 2), "R8 equal names");

        // R10: unused op codes change nothing
        for (int op = 5; op < 8; op++) do_cmd(3'(op), 5'd20, blk_of(21), blk_of(22));
        look2(mk(blk_of(20), 3), mk(blk_of(22), 3), "R10 unused op");

        // R2: final sweep against the tracked table
        for (int i = 0; i < 32; i++) look2(mk(blk_of(i), i * 13), mk(blk_of(i), 511), "R2 final sweep");
        idle_check("R12 final idle");

        finish_run();
    end

endmodule